// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Requests

This block sits between a bus-side data port and an audio serial engine. It holds two sample queues: a transmit queue that the bus side fills and the serializer drains one sample at a time, and a receive queue that the serializer fills and the bus side drains. Each queue drives a service request to a DMA engine. The transmit request is raised while the transmit fill level is low enough to take another burst. The receive request is raised once enough samples have gathered to be worth collecting.

Each queue has a self-clearing flush bit. In shared-flush mode the transmit flush empties both queues, and the receive flush does nothing. When the serializer pops an empty transmit queue, a sticky underrun flag is set. The sample sent in that case is either the last sample popped or zero, depending on the replay option. A push into a full receive queue sets a sticky overrun flag, and the sample is dropped. Each flag has a mask bit that gates it onto a single interrupt line.

Top module: `audio_fifo_pair`

## Requirements
- R1: After reset both queues are empty, both flags and both flush bits are 0, the transmit threshold is 8 and the receive threshold is 7. The transmit request is therefore 1, and the receive request and the interrupt are 0.
- R2: Each queue holds 32 16-bit samples and delivers them in the order they were written. A write into a full transmit queue, or a read from an empty receive queue, is ignored. The transmit head sample is visible on `ser_tx_data` and the receive head sample on `rx_rd_data` without waiting for a clock.
- R3: `tx_req` is 1 exactly while `tx_level` is less than or equal to the transmit threshold. It follows the level in the same cycle.
- R4: `rx_req` is 1 exactly while `rx_level` is greater than or equal to the receive threshold.
- R5: A cycle with `cfg_thr_we` high loads the 4-bit values `cfg_tx_thr` and `cfg_rx_thr` as the new thresholds at that clock edge.
- R6: A pulse on `tx_flush_set` sets `tx_flush_busy` at the next edge. At the edge after that, the transmit level becomes 0 and `tx_flush_busy` clears. In separate mode (`shared_flush`=0) the receive queue is untouched.
- R7: In separate mode, a pulse on `rx_flush_set` empties only the receive queue, with the same two-edge timing, and sets `rx_flush_busy` for one cycle.
- R8: With `shared_flush`=1, a pulse on `tx_flush_set` empties both queues, and both busy bits are high for one cycle. A pulse on `rx_flush_set` leaves the receive level unchanged and does not set `rx_flush_busy`.
- R9: A pop while the transmit queue is empty sets `tx_underrun` at that edge. While the queue is empty, `ser_tx_data` shows the last popped sample if `replay_en`=1, and 0 if `replay_en`=0.
- R10: A push while the receive queue is full sets `rx_overrun` at that edge. The sample is dropped, and the queue contents and level are unchanged.
- R11: `tx_underrun` and `rx_overrun` stay set until a pulse on `unr_clr` or `ovr_clr` respectively, which clears the flag at that edge.
- R12: `irq` is (`tx_underrun` AND `unr_irq_en`) OR (`rx_overrun` AND `ovr_irq_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wr_en | input | 1 | Bus-side write into the transmit queue |
| tx_wr_data | input | 16 | Sample written into the transmit queue |
| rx_rd_en | input | 1 | Bus-side read (pop) from the receive queue |
| rx_rd_data | output | 16 | Head sample of the receive queue |
| ser_tx_pop | input | 1 | Serializer takes the transmit sample |
| ser_tx_data | output | 16 | Sample offered to the serializer |
| ser_rx_push | input | 1 | Serializer delivers a received sample |
| ser_rx_data | input | 16 | Received sample |
| cfg_thr_we | input | 1 | Load new thresholds |
| cfg_tx_thr | input | 4 | New transmit threshold |
| cfg_rx_thr | input | 4 | New receive threshold |
| shared_flush | input | 1 | 1: transmit flush empties both queues |
| tx_flush_set | input | 1 | Request a transmit flush |
| rx_flush_set | input | 1 | Request a receive flush |
| tx_flush_busy | output | 1 | Transmit flush bit (self-clearing) |
| rx_flush_busy | output | 1 | Receive flush bit (self-clearing) |
| replay_en | input | 1 | 1: repeat the last sample on underrun; 0: send zero |
| unr_irq_en | input | 1 | Interrupt mask for underrun |
| ovr_irq_en | input | 1 | Interrupt mask for overrun |
| unr_clr | input | 1 | Clear the underrun flag |
| ovr_clr | input | 1 | Clear the overrun flag |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| tx_level | output | 6 | Transmit fill level |
| rx_level | output | 6 | Receive fill level |
| tx_underrun | output | 1 | Sticky underrun flag |
| rx_overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench steps the fill levels through each threshold boundary, one sample at a time. A design that used a strict comparison, or compared against the wrong threshold, would move a request one sample early or late.

Both queues are overfilled to show that the extra sample is dropped. A design whose pointers wrapped would overwrite the oldest sample and lose its order. The same overfill checks that the overrun flag stays set until it is cleared.

The empty-pop case is checked with replay on and with replay off. A design that cleared the held sample, or ignored the option, would send the wrong value. Flushes are checked in both modes with the other queue partly full. A flush that leaked into the other queue, or a receive flush honoured in shared mode, would change a level the bench samples.

// File: rtl/afifo_pkg.sv
// Package: shared sizing defaults for the audio sample FIFO pair.
// Assumes the depth is a power of two and leaves room for one 16-sample
// burst above the largest 4-bit threshold.
package afifo_pkg;
    localparam int SAMPLE_W   = 16;
    localparam int FIFO_DEPTH = 32;
    localparam int THR_W      = 4;
    localparam int BURST_LEN  = 16;
    localparam int DEF_TX_THR = 8;
    localparam int DEF_RX_THR = 7;
endpackage

// File: rtl/sample_fifo.sv
// Module: sample_fifo
// Synchronous queue with a fill counter and a look-ahead head output.
// A push into a full queue and a pop from an empty queue are ignored.
// `clear` empties the queue and takes priority over push and pop.
// Assumes DEPTH is a power of two, so the pointers wrap on their own.
module sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] count;
    logic          push_ok, pop_ok;

    assign full    = (count == LW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign level   = count;

    // Purpose: advance the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Purpose: store accepted samples.
    always_ff @(posedge clk) begin
        if (rst_n && !clear && push_ok) mem[wr_ptr] <= push_data;
    end

    // R2: the fill count never exceeds the depth.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LW'(DEPTH));

    // R6: a clear leaves the queue empty at the next edge.
    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));
endmodule

// File: rtl/flush_ctrl.sv
// Module: flush_ctrl
// Holds the two self-clearing flush bits. A set pulse raises a bit at the
// next edge. The bit then drives its queue's clear for one cycle and drops.
// In shared mode the transmit request raises both bits, and the receive
// request is ignored.
module flush_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic shared_mode,
    input  logic tx_set,
    input  logic rx_set,
    output logic tx_bit,
    output logic rx_bit
);
    // Purpose: register the flush bits; each lasts one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit <= 1'b0;
            rx_bit <= 1'b0;
        end else begin
            tx_bit <= tx_set;
            rx_bit <= shared_mode ? tx_set : rx_set;
        end
    end

    // R6: the transmit bit clears itself one cycle after it takes effect.
    assert_tx_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bit && !tx_set) |=> !tx_bit);

    // R7: the receive bit clears itself too.
    assert_rx_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bit && !rx_set && !tx_set) |=> !rx_bit);

    // R8: in shared mode a receive request alone never raises the receive bit.
    assert_shared_ignores_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_mode && rx_set && !tx_set) |=> !rx_bit);
endmodule

// File: rtl/audio_fifo_pair.sv
// Module: audio_fifo_pair
// Transmit and receive sample queues between a bus/DMA port and an audio
// serializer. The block drives threshold requests, self-clearing flushes
// (separate or shared), sticky underrun and overrun flags, a masked
// interrupt, and a choice of repeating the last sample or sending zero on
// underrun. Assumes a single clock domain and a synchronous active-low reset.
module audio_fifo_pair
    import afifo_pkg::*;
#(
    parameter int W      = SAMPLE_W,
    parameter int DEPTH  = FIFO_DEPTH,
    parameter int TW     = THR_W,
    parameter int TX_THR = DEF_TX_THR,
    parameter int RX_THR = DEF_RX_THR
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_wr_en,
    input  logic [W-1:0]               tx_wr_data,
    input  logic                       rx_rd_en,
    output logic [W-1:0]               rx_rd_data,
    input  logic                       ser_tx_pop,
    output logic [W-1:0]               ser_tx_data,
    input  logic                       ser_rx_push,
    input  logic [W-1:0]               ser_rx_data,
    input  logic                       cfg_thr_we,
    input  logic [TW-1:0]              cfg_tx_thr,
    input  logic [TW-1:0]              cfg_rx_thr,
    input  logic                       shared_flush,
    input  logic                       tx_flush_set,
    input  logic                       rx_flush_set,
    output logic                       tx_flush_busy,
    output logic                       rx_flush_busy,
    input  logic                       replay_en,
    input  logic                       unr_irq_en,
    input  logic                       ovr_irq_en,
    input  logic                       unr_clr,
    input  logic                       ovr_clr,
    output logic                       tx_req,
    output logic                       rx_req,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       tx_underrun,
    output logic                       rx_overrun,
    output logic                       irq
);
    localparam int LW = $clog2(DEPTH+1);

    logic [TW-1:0] tx_thr_q, rx_thr_q;
    logic [W-1:0]  tx_head, last_q;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          unr_q, ovr_q;

    // Flush bits
    flush_ctrl u_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .shared_mode (shared_flush),
        .tx_set      (tx_flush_set),
        .rx_set      (rx_flush_set),
        .tx_bit      (tx_flush_busy),
        .rx_bit      (rx_flush_busy)
    );

    // Transmit queue: bus writes, serializer pops
    sample_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tx_flush_busy),
        .push      (tx_wr_en),
        .push_data (tx_wr_data),
        .pop       (ser_tx_pop),
        .head      (tx_head),
        .level     (tx_level),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    // Receive queue: serializer pushes, bus reads
    sample_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_flush_busy),
        .push      (ser_rx_push),
        .push_data (ser_rx_data),
        .pop       (rx_rd_en),
        .head      (rx_rd_data),
        .level     (rx_level),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    // Purpose: hold the programmable thresholds, loaded with their defaults at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_q <= TW'(TX_THR);
            rx_thr_q <= TW'(RX_THR);
        end else if (cfg_thr_we) begin
            tx_thr_q <= cfg_tx_thr;
            rx_thr_q <= cfg_rx_thr;
        end
    end

    // Purpose: remember the most recent sample handed to the serializer.
    always_ff @(posedge clk) begin
        if (!rst_n)                       last_q <= '0;
        else if (ser_tx_pop && !tx_empty) last_q <= tx_head;
    end

    // Purpose: sticky underrun and overrun flags; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unr_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (ser_tx_pop && tx_empty) unr_q <= 1'b1;
            else if (unr_clr)           unr_q <= 1'b0;
            if (ser_rx_push && rx_full) ovr_q <= 1'b1;
            else if (ovr_clr)           ovr_q <= 1'b0;
        end
    end

    assign ser_tx_data = !tx_empty ? tx_head : (replay_en ? last_q : '0);
    assign tx_req      = (tx_level <= LW'(tx_thr_q));
    assign rx_req      = (rx_level >= LW'(rx_thr_q));
    assign tx_underrun = unr_q;
    assign rx_overrun  = ovr_q;
    assign irq         = (unr_q && unr_irq_en) || (ovr_q && ovr_irq_en);

    // R9: a pop on an empty transmit queue raises the underrun flag.
    assert_underrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_tx_pop && tx_empty) |=> tx_underrun);

    // R9: after the last sample leaves, replay mode keeps offering it.
    assert_replay_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_tx_pop && tx_level == LW'(1) && !tx_wr_en && !tx_flush_busy)
        |=> (!replay_en || ser_tx_data == $past(tx_head)));

    // R10: a push into a full receive queue raises the overrun flag.
    assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && rx_full) |=> rx_overrun);

    // R10: the rejected sample does not change the receive level.
    assert_overrun_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && rx_full && !rx_rd_en && !rx_flush_busy)
        |=> (rx_level == $past(rx_level)));

    // R11: the underrun flag holds without a clear.
    assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underrun && !unr_clr) |=> tx_underrun);

    // R11: the overrun flag holds without a clear.
    assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !ovr_clr) |=> rx_overrun);
endmodule

// File: tb/audio_fifo_pair_bench.sv
module audio_fifo_pair_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_wr_en, rx_rd_en, ser_tx_pop, ser_rx_push;
    logic [15:0] tx_wr_data, ser_rx_data, rx_rd_data, ser_tx_data;
    logic        cfg_thr_we;
    logic [3:0]  cfg_tx_thr, cfg_rx_thr;
    logic        shared_flush, tx_flush_set, rx_flush_set;
    logic        tx_flush_busy, rx_flush_busy;
    logic        replay_en, unr_irq_en, ovr_irq_en, unr_clr, ovr_clr;
    logic        tx_req, rx_req, tx_underrun, rx_overrun, irq;
    logic [5:0]  tx_level, rx_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_fifo_pair u_audio_fifo_pair (
        .clk(clk), .rst_n(rst_n),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .cfg_thr_we(cfg_thr_we), .cfg_tx_thr(cfg_tx_thr), .cfg_rx_thr(cfg_rx_thr),
        .shared_flush(shared_flush), .tx_flush_set(tx_flush_set), .rx_flush_set(rx_flush_set),
        .tx_flush_busy(tx_flush_busy), .rx_flush_busy(rx_flush_busy),
        .replay_en(replay_en), .unr_irq_en(unr_irq_en), .ovr_irq_en(ovr_irq_en),
        .unr_clr(unr_clr), .ovr_clr(ovr_clr),
        .tx_req(tx_req), .rx_req(rx_req), .tx_level(tx_level), .rx_level(rx_level),
        .tx_underrun(tx_underrun), .rx_overrun(rx_overrun), .irq(irq)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Inputs change at the falling edge; outputs are read there too.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tx_write(logic [15:0] d);
        tx_wr_en = 1; tx_wr_data = d; tick(); tx_wr_en = 0;
    endtask

    task automatic rx_push(logic [15:0] d);
        ser_rx_push = 1; ser_rx_data = d; tick(); ser_rx_push = 0;
    endtask

    task automatic tx_pop(); ser_tx_pop = 1; tick(); ser_tx_pop = 0; endtask
    task automatic rx_read(); rx_rd_en = 1; tick(); rx_rd_en = 0; endtask

    task automatic flush_both();
        tx_flush_set = 1; rx_flush_set = 1; tick();
        tx_flush_set = 0; rx_flush_set = 0; tick();
    endtask

    task automatic test_reset();
        check("R1 tx_level", tx_level, 0);
        check("R1 rx_level", rx_level, 0);
        check("R1 tx_req", tx_req, 1);
        check("R1 rx_req", rx_req, 0);
        check("R1 flags", {tx_underrun, rx_overrun, irq}, 0);
        check("R1 busy", {tx_flush_busy, rx_flush_busy}, 0);
    endtask

    task automatic test_tx_order_thresh();
        for (int i = 0; i < 10; i++) begin
            tx_write(16'h0100 + 16'(i));
            check("R3 tx_req at level", tx_req, (i + 1 <= 8) ? 1 : 0);
        end
        check("R2 tx_level", tx_level, 10);
        for (int i = 0; i < 10; i++) begin
            check("R2 tx order", ser_tx_data, 16'h0100 + i);
            tx_pop();
        end
        check("R3 tx_req empty", tx_req, 1);
        check("R9 no underrun", tx_underrun, 0);
    endtask

    task automatic test_tx_full();
        for (int i = 0; i < 34; i++) tx_write(16'h3000 + 16'(i));
        check("R2 tx full level", tx_level, 32);
        for (int i = 0; i < 32; i++) begin
            check("R2 tx full order", ser_tx_data, 16'h3000 + i);
            tx_pop();
        end
        check("R2 tx drained", tx_level, 0);
    endtask

    task automatic test_underrun_replay();
        replay_en = 1;
        tx_write(16'hABCD);
        tx_pop();
        check("R9 replay held", ser_tx_data, 16'hABCD);
        check("R9 no flag yet", tx_underrun, 0);
        tx_pop();
        check("R9 underrun set", tx_underrun, 1);
        check("R9 replay after underrun", ser_tx_data, 16'hABCD);
        replay_en = 0;
        #1;
        check("R9 zero without replay", ser_tx_data, 0);
        check("R12 masked", irq, 0);
        unr_irq_en = 1;
        #1;
        check("R12 unmasked", irq, 1);
        tick(); tick();
        check("R11 sticky underrun", tx_underrun, 1);
        unr_clr = 1; tick(); unr_clr = 0;
        check("R11 underrun cleared", tx_underrun, 0);
        check("R12 irq low", irq, 0);
        unr_irq_en = 0;
    endtask

    task automatic test_rx_overrun();
        for (int i = 0; i < 32; i++) begin
            rx_push(16'h0200 + 16'(i));
            check("R4 rx_req at level", rx_req, (i + 1 >= 7) ? 1 : 0);
        end
        rx_push(16'hDEAD);
        check("R10 overrun set", rx_overrun, 1);
        check("R10 level kept", rx_level, 32);
        ovr_irq_en = 1;
        #1;
        check("R12 overrun irq", irq, 1);
        for (int i = 0; i < 32; i++) begin
            check("R10 rx order", rx_rd_data, 16'h0200 + i);
            rx_read();
        end
        check("R2 rx empty", rx_level, 0);
        rx_read();
        check("R2 empty read ignored", rx_level, 0);
        check("R11 sticky overrun", rx_overrun, 1);
        ovr_clr = 1; tick(); ovr_clr = 0;
        check("R11 overrun cleared", rx_overrun, 0);
        ovr_irq_en = 0;
    endtask

    task automatic test_cfg();
        cfg_tx_thr = 4'd2; cfg_rx_thr = 4'd3; cfg_thr_we = 1; tick(); cfg_thr_we = 0;
        tx_write(16'h1); tx_write(16'h2);
        check("R5 tx_req at 2", tx_req, 1);
        tx_write(16'h3);
        check("R5 tx_req at 3", tx_req, 0);
        rx_push(16'h1); rx_push(16'h2);
        check("R5 rx_req at 2", rx_req, 0);
        rx_push(16'h3);
        check("R5 rx_req at 3", rx_req, 1);
        cfg_tx_thr = 4'd8; cfg_rx_thr = 4'd7; cfg_thr_we = 1; tick(); cfg_thr_we = 0;
    endtask

    task automatic test_flush_separate();
        shared_flush = 0;
        tx_flush_set = 1; tick(); tx_flush_set = 0;
        check("R6 tx busy", tx_flush_busy, 1);
        check("R6 rx busy idle", rx_flush_busy, 0);
        check("R6 level before", tx_level, 3);
        tick();
        check("R6 tx flushed", tx_level, 0);
        check("R6 tx busy clear", tx_flush_busy, 0);
        check("R6 rx untouched", rx_level, 3);
        tx_write(16'h5); tx_write(16'h6);
        rx_flush_set = 1; tick(); rx_flush_set = 0;
        check("R7 rx busy", rx_flush_busy, 1);
        tick();
        check("R7 rx flushed", rx_level, 0);
        check("R7 rx busy clear", rx_flush_busy, 0);
        check("R7 tx untouched", tx_level, 2);
    endtask

    task automatic test_flush_shared();
        shared_flush = 1;
        rx_push(16'h7); rx_push(16'h8);
        rx_flush_set = 1; tick(); rx_flush_set = 0;
        check("R8 rx busy ignored", rx_flush_busy, 0);
        tick();
        check("R8 rx kept", rx_level, 2);
        tx_flush_set = 1; tick(); tx_flush_set = 0;
        check("R8 both busy", {tx_flush_busy, rx_flush_busy}, 3);
        tick();
        check("R8 tx flushed", tx_level, 0);
        check("R8 rx flushed", rx_level, 0);
        shared_flush = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        rst_n = 0;
        tx_wr_en = 0; tx_wr_data = 0; rx_rd_en = 0; ser_tx_pop = 0;
        ser_rx_push = 0; ser_rx_data = 0; cfg_thr_we = 0; cfg_tx_thr = 0; cfg_rx_thr = 0;
        shared_flush = 0; tx_flush_set = 0; rx_flush_set = 0; replay_en = 0;
        unr_irq_en = 0; ovr_irq_en = 0; unr_clr = 0; ovr_clr = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        test_reset();
        test_tx_order_thresh();
        test_tx_full();
        test_underrun_replay();
        test_rx_overrun();
        test_cfg();
        test_flush_separate();
        test_flush_shared();
        flush_both();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule